// File: doc/BRIEF.md
# Transition-Triggered SRAM Access Timer

This block produces the internal strobes of a static RAM access without a dedicated memory clock. A detector compares the chip-select, write-enable and address inputs with their values one system clock earlier. Any difference while the chip is selected starts a one-shot sequence. The sequence precharges the bit lines, raises one word line, and then does one of two things. On a read it readies and fires the sense amplifier, opens the column switch and strobes the output latch. On a write it fires the write driver through the column switch. When the last phase ends, the block falls back to a power-down idle state. No strobe moves while the inputs stay still, and that is the point of the scheme: the array draws power only around a real access.

Each phase lasts a parameterized number of system clock cycles, so the sequence can be exercised in a cycle-based model. The row address is decoded in two stages: groups of upper row bits first, and then the word-line driver, which resolves the lowest row bit. A behavioural register file stands in for the cell array, so that reads and writes can be observed at the ports.

Top module: `sram_atd_timer`

## Requirements
- R1: While reset is applied and on the first cycle after it, `pd_o` is 1, every strobe and every word/column select is 0, and `rdata_o` is 0.
- R2: While `cs_i`, `we_i` and `addr_i` keep their values and no sequence is running, `pd_o` stays 1 and no strobe is asserted.
- R3: A change on `cs_i`, `we_i` or `addr_i`, seen at a clock edge with `cs_i` high, starts the sequence: `pre_o` is high from that edge for exactly T_PRE cycles.
- R4: In a read (`we_i` = 0 when the sequence started), precharge is followed by T_WL cycles of word line plus `sa_pre_o`, and then by T_SNS cycles of word line plus `sae_o` plus column select. After that comes idle with `pd_o` = 1.
- R5: In a write (`we_i` = 1 when the sequence started), precharge is followed by T_WL cycles of word line alone, and then by T_SNS cycles of word line plus `wde_o` plus column select. `sa_pre_o`, `sae_o` and `olat_o` stay 0, and `sae_o` and `wde_o` are never high together.
- R6: `olat_o` is high only in the last sense cycle. `rdata_o` takes the addressed word at the edge that ends that cycle and holds its value at all other times.
- R7: The word held in `wdata_i` when a write started is stored at the end of its drive phase and is returned by a later read of the same address.
- R8: With `cs_i` low, no sequence starts. A transition seen with `cs_i` low (including `cs_i` falling) ends any running sequence at once, with no data captured and no word stored.
- R9: A transition with `cs_i` high during a running sequence restarts it at precharge, using the new address and direction.
- R10: The address is {row, column} with the column in the low COL_W bits. During word-line phases exactly `wl_sel_o[row]` is high, during sense or drive phases exactly `col_sel_o[column]` is high, and at all other times both are 0.
- R11: Bit-line precharge and word-line enable never overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that times the phases |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| we_i | input | 1 | 1 = write access, 0 = read access |
| addr_i | input | ROW_W+COL_W | Word address, row in the upper bits |
| wdata_i | input | DATA_W | Write data, taken when a sequence starts |
| rdata_o | output | DATA_W | Output latch contents |
| pd_o | output | 1 | Power-down idle indicator |
| pre_o | output | 1 | Bit-line precharge strobe |
| wl_sel_o | output | 2**ROW_W | One-hot word-line enables |
| sa_pre_o | output | 1 | Sense-node mid-level precharge |
| sae_o | output | 1 | Sense-amplifier enable |
| wde_o | output | 1 | Write-driver enable |
| col_sel_o | output | 2**COL_W | One-hot column switch enables |
| olat_o | output | 1 | Output latch strobe |

## Verification
A wrong phase or counter value appears at the ports within a cycle as a strobe pattern out of order, or as a phase that is one cycle short or long. So the bench compares the full strobe vector on every cycle of each access. A wrong held direction or address shows up later instead: as a missing or stray write driver, or as the wrong word in `rdata_o` after the latch strobe. Reads back to back of words written earlier expose that. The aborted-write and restart cases show whether a sequence that was cut short left any trace in the array or the output latch.

// File: rtl/sram_atd_pkg.sv
package sram_atd_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_PRE   = 3'd1,
    PH_WL    = 3'd2,
    PH_SENSE = 3'd3,
    PH_DRIVE = 3'd4
  } phase_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_atd_detect.sv
// Compares the watched inputs with their value one cycle earlier.
module sram_atd_detect #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] watch_i,
  output logic             change_o
);

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] prev_d;

  always_comb begin
    prev_d = watch_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
    end else begin
      prev_q <= prev_d;
    end
  end

  assign change_o = |(watch_i ^ prev_q);

endmodule

// File: rtl/sram_atd_seq.sv
// One-shot phase sequencer with a per-phase down counter.
module sram_atd_seq
  import sram_atd_pkg::*;
#(
  parameter int unsigned T_PRE = 2,
  parameter int unsigned T_WL  = 3,
  parameter int unsigned T_SNS = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   abort_i,
  input  logic   write_i,
  output phase_e phase_o,
  output logic   last_o
);

  localparam int unsigned TMAX  = max3(T_PRE, T_WL, T_SNS);
  localparam int unsigned CNT_W = $clog2(TMAX + 1);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd_en;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (abort_i) begin
      ph_d  = PH_IDLE;
      cnt_d = '0;
    end else if (start_i) begin
      ph_d  = PH_PRE;
      cnt_d = CNT_W'(T_PRE - 1);
    end else if (ph_q != PH_IDLE) begin
      if (cnt_q == '0) begin
        case (ph_q)
          PH_PRE: begin
            ph_d  = PH_WL;
            cnt_d = CNT_W'(T_WL - 1);
          end
          PH_WL: begin
            ph_d  = write_i ? PH_DRIVE : PH_SENSE;
            cnt_d = CNT_W'(T_SNS - 1);
          end
          default: begin
            ph_d  = PH_IDLE;
            cnt_d = '0;
          end
        endcase
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  assign upd_en = abort_i | start_i | (ph_q != PH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (upd_en) begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase_o = ph_q;
  assign last_o  = (ph_q != PH_IDLE) && (cnt_q == '0);

endmodule

// File: rtl/sram_row_decode.sv
// Two-stage row decode: upper row bits predecoded into group lines,
// the word-line driver stage resolves the lowest row bit.
module sram_row_decode #(
  parameter int unsigned ROW_W = 4
) (
  input  logic [ROW_W-1:0]      row_i,
  input  logic                  en_i,
  output logic [(1<<ROW_W)-1:0] wl_o
);

  localparam int unsigned ROWS   = 1 << ROW_W;
  localparam int unsigned GROUPS = 1 << (ROW_W - 1);

  logic [GROUPS-1:0] grp;

  generate
    if (ROW_W > 1) begin : g_predec
      for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign grp[g] = (row_i[ROW_W-1:1] == (ROW_W-1)'(g));
      end
    end else begin : g_single
      assign grp[0] = 1'b1;
    end
  endgenerate

  generate
    for (genvar r = 0; r < ROWS; r++) begin : g_drv
      assign wl_o[r] = en_i & grp[r/2] & (row_i[0] == 1'(r % 2));
    end
  endgenerate

endmodule

// File: rtl/sram_cell_array.sv
// Behavioural stand-in for the cell array plus the output latch.
module sram_cell_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int unsigned WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [WORDS];
  logic [DATA_W-1:0] rdata_q, rdata_d;

  always_ff @(posedge clk_i) begin
    if (wr_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_d = mem_q[addr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/sram_atd_timer.sv
module sram_atd_timer
  import sram_atd_pkg::*;
#(
  parameter int unsigned ROW_W  = 4,
  parameter int unsigned COL_W  = 2,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned T_PRE  = 2,
  parameter int unsigned T_WL   = 3,
  parameter int unsigned T_SNS  = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cs_i,
  input  logic                  we_i,
  input  logic [ROW_W+COL_W-1:0] addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic                  pd_o,
  output logic                  pre_o,
  output logic [(1<<ROW_W)-1:0] wl_sel_o,
  output logic                  sa_pre_o,
  output logic                  sae_o,
  output logic                  wde_o,
  output logic [(1<<COL_W)-1:0] col_sel_o,
  output logic                  olat_o
);

  localparam int unsigned ADDR_W  = ROW_W + COL_W;
  localparam int unsigned ROWS    = 1 << ROW_W;
  localparam int unsigned COLS    = 1 << COL_W;
  localparam int unsigned WATCH_W = ADDR_W + 2;

  logic              change;
  logic              start;
  logic              abort;
  phase_e            phase;
  logic              last;
  logic              row_en;
  logic              col_en;
  logic              commit;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              we_q, we_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;

  sram_atd_detect #(
    .WIDTH(WATCH_W)
  ) u_detect (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .watch_i ({cs_i, we_i, addr_i}),
    .change_o(change)
  );

  assign start = change & cs_i;
  assign abort = change & ~cs_i;

  // Access parameters held for the whole sequence
  always_comb begin
    addr_d  = addr_i;
    we_d    = we_i;
    wdata_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else if (start) begin
      addr_q  <= addr_d;
      we_q    <= we_d;
      wdata_q <= wdata_d;
    end
  end

  sram_atd_seq #(
    .T_PRE(T_PRE),
    .T_WL (T_WL),
    .T_SNS(T_SNS)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .abort_i(abort),
    .write_i(we_q),
    .phase_o(phase),
    .last_o (last)
  );

  // Strobe decode
  assign pd_o     = (phase == PH_IDLE);
  assign pre_o    = (phase == PH_PRE);
  assign row_en   = (phase == PH_WL) || (phase == PH_SENSE) || (phase == PH_DRIVE);
  assign col_en   = (phase == PH_SENSE) || (phase == PH_DRIVE);
  assign sa_pre_o = (phase == PH_WL) && !we_q;
  assign sae_o    = (phase == PH_SENSE);
  assign wde_o    = (phase == PH_DRIVE);
  assign olat_o   = (phase == PH_SENSE) && last;
  assign commit   = (phase == PH_DRIVE) && last;

  sram_row_decode #(
    .ROW_W(ROW_W)
  ) u_row (
    .row_i(addr_q[ADDR_W-1:COL_W]),
    .en_i (row_en),
    .wl_o (wl_sel_o)
  );

  generate
    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign col_sel_o[c] = col_en & (addr_q[COL_W-1:0] == COL_W'(c));
    end
  endgenerate

  sram_cell_array #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_q),
    .wdata_i(wdata_q),
    .wr_i   (commit),
    .rd_i   (olat_o),
    .rdata_o(rdata_o)
  );

endmodule

// File: rtl/sram_atd_chk.sv
module sram_atd_chk #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ROWS   = 16,
  parameter int unsigned COLS   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              pd_o,
  input logic              pre_o,
  input logic [ROWS-1:0]   wl_sel_o,
  input logic              sa_pre_o,
  input logic              sae_o,
  input logic              wde_o,
  input logic [COLS-1:0]   col_sel_o,
  input logic              olat_o
);

  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
    end
  end

  // R11
  pre_wl_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pre_o && (|wl_sel_o)));

  // R10
  wl_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wl_sel_o));

  // R10
  col_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(col_sel_o));

  // R5
  sae_wde_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sae_o && wde_o));

  // R4
  sa_pre_wl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sa_pre_o |-> (|wl_sel_o));

  // R6
  olat_in_sense_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    olat_o |-> (sae_o && (|col_sel_o)));

  // R6
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    !olat_o |=> $stable(rdata_o));

  // R2
  quiet_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (pd_o && $stable(cs_i) && $stable(we_i) && $stable(addr_i)) |=> pd_o);

  // R8
  cs_low_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (!cs_i && !$past(cs_i)) |-> (pd_o && !pre_o && !(|wl_sel_o) && !wde_o && !olat_o));

endmodule

bind sram_atd_timer sram_atd_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .ROWS  (ROWS),
  .COLS  (COLS)
) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_i     (cs_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .pd_o     (pd_o),
  .pre_o    (pre_o),
  .wl_sel_o (wl_sel_o),
  .sa_pre_o (sa_pre_o),
  .sae_o    (sae_o),
  .wde_o    (wde_o),
  .col_sel_o(col_sel_o),
  .olat_o   (olat_o)
);

// File: tb/test_sram_atd_timer.sv
module test_sram_atd_timer;

  localparam int TP  = 2;
  localparam int TW  = 3;
  localparam int TS  = 2;
  localparam int TOT = TP + TW + TS;

  logic        clk;
  logic        rst_n;
  logic        cs;
  logic        we;
  logic [5:0]  addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata_o;
  logic        pd_o, pre_o, sa_pre_o, sae_o, wde_o, olat_o;
  logic [15:0] wl_sel_o;
  logic [3:0]  col_sel_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [7:0] model [64];

  sram_atd_timer #(
    .ROW_W(4), .COL_W(2), .DATA_W(8), .T_PRE(TP), .T_WL(TW), .T_SNS(TS)
  ) i_sram_atd_timer (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_o), .pd_o(pd_o), .pre_o(pre_o),
    .wl_sel_o(wl_sel_o), .sa_pre_o(sa_pre_o), .sae_o(sae_o), .wde_o(wde_o),
    .col_sel_o(col_sel_o), .olat_o(olat_o)
  );

  // {pd, pre, any word line, sense-node precharge, sense, write drive, latch, any column}
  wire [7:0] sv = {pd_o, pre_o, |wl_sel_o, sa_pre_o, sae_o, wde_o, olat_o, |col_sel_o};

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] expv(input bit wr, input int c);
    if (c >= 1 && c <= TP)           return 8'b0100_0000;
    else if (c >= 1 && c <= TP + TW) return {2'b00, 1'b1, ~wr, 4'b0000};
    else if (c >= 1 && c <= TOT)     return {3'b001, 1'b0, ~wr, wr, (~wr && c == TOT), 1'b1};
    else                             return 8'b1000_0000;
  endfunction

  // Checks every cycle of one access; call right after its inputs were driven.
  task automatic trace(input bit wr, input logic [5:0] a, input logic [7:0] d,
                       input string req);
    logic [7:0] old;
    old = rdata_o;
    for (int c = 1; c <= TOT + 3; c++) begin
      @(negedge clk);
      chk(sv == expv(wr, c), req, $sformatf("strobes cycle %0d", c), 32'(sv), 32'(expv(wr, c)));
      if (c > TP && c <= TOT)
        chk(wl_sel_o == (16'h1 << a[5:2]), "R10", "word line", 32'(wl_sel_o), 32'(16'h1 << a[5:2]));
      if (c > TP + TW && c <= TOT)
        chk(col_sel_o == (4'h1 << a[1:0]), "R10", "column", 32'(col_sel_o), 32'(4'h1 << a[1:0]));
      if (!wr && c == TOT)
        chk(rdata_o == old, "R6", "latch before strobe", 32'(rdata_o), 32'(old));
    end
    if (wr) model[a] = d;
    else chk(rdata_o == model[a], "R7", "read data", 32'(rdata_o), 32'(model[a]));
  endtask

  task automatic access(input bit wr, input logic [5:0] a, input logic [7:0] d,
                        input string req);
    @(negedge clk);
    cs = 1'b1; we = wr; addr = a; wdata = d;
    trace(wr, a, d, req);
  endtask

  task automatic t_reset;
    cs = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(sv == 8'h80 && wl_sel_o == '0 && col_sel_o == '0, "R1", "strobes in reset", 32'(sv), 32'h80);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sv == 8'h80, "R1", "strobes after reset", 32'(sv), 32'h80);
    chk(rdata_o == 8'h00, "R1", "rdata after reset", 32'(rdata_o), 32'h0);
  endtask

  task automatic t_write_read;
    access(1'b1, 6'h05, 8'h3C, "R3 R5 write");
    access(1'b1, 6'h2E, 8'hA7, "R5 write");
    access(1'b0, 6'h05, 8'h00, "R4 read");
    access(1'b0, 6'h2E, 8'h00, "R4 read");
  endtask

  task automatic t_boundary;
    access(1'b1, 6'h00, 8'hFF, "R5 write low corner");
    access(1'b1, 6'h3F, 8'h00, "R5 write high corner");
    access(1'b0, 6'h00, 8'h00, "R4 read low corner");
    access(1'b0, 6'h3F, 8'h00, "R4 read high corner");
  endtask

  task automatic t_quiet;
    logic [7:0] held;
    held = rdata_o;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(sv == 8'h80, "R2", "stable inputs", 32'(sv), 32'h80);
    end
    chk(rdata_o == held, "R2", "rdata with stable inputs", 32'(rdata_o), 32'(held));
  endtask

  task automatic t_cs_low;
    logic [7:0] held;
    held = rdata_o;
    @(negedge clk);
    cs = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(sv == 8'h80, "R8", "deselected", 32'(sv), 32'h80);
      addr = 6'(i * 5);
      we = ~we;
    end
    @(negedge clk);
    chk(rdata_o == held, "R8", "rdata deselected", 32'(rdata_o), 32'(held));
  endtask

  task automatic t_abort;
    logic [7:0] held;
    held = rdata_o;
    @(negedge clk);
    cs = 1'b1; we = 1'b0; addr = 6'h2E;
    repeat (4) @(negedge clk);
    cs = 1'b0;
    @(negedge clk);
    chk(sv == 8'h80, "R8", "read aborted", 32'(sv), 32'h80);
    repeat (8) @(negedge clk);
    chk(rdata_o == held, "R8", "aborted read latch", 32'(rdata_o), 32'(held));
    cs = 1'b1; we = 1'b1; addr = 6'h05; wdata = 8'h99;
    repeat (TOT - 1) @(negedge clk);
    chk(wde_o == 1'b1, "R8", "in drive before abort", 32'(wde_o), 32'h1);
    cs = 1'b0;
    @(negedge clk);
    chk(sv == 8'h80, "R8", "write aborted", 32'(sv), 32'h80);
    access(1'b0, 6'h05, 8'h00, "R8 word kept after aborted write");
  endtask

  task automatic t_restart;
    logic [7:0] held;
    held = rdata_o;
    @(negedge clk);
    cs = 1'b1; we = 1'b0; addr = 6'h00;
    repeat (TP + 2) @(negedge clk);
    chk(rdata_o == held, "R9", "no latch before restart", 32'(rdata_o), 32'(held));
    addr = 6'h2E;
    trace(1'b0, 6'h2E, 8'h00, "R9 restart read");
    @(negedge clk);
    we = 1'b1; addr = 6'h11; wdata = 8'h42;
    repeat (TP) @(negedge clk);
    addr = 6'h12;
    trace(1'b1, 6'h12, 8'h42, "R9 restart write");
    access(1'b0, 6'h12, 8'h00, "R9 restarted write stored");
  endtask

  initial begin
    t_reset();
    t_write_read();
    t_boundary();
    t_quiet();
    t_cs_low();
    t_abort();
    t_restart();
    t_quiet();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule